// File: doc/BRIEF.md
# Serial Receive Holding Register and Status Flags

This block sits between the receive shift path of a serial port and the CPU bus. When the shift path finishes a frame, it raises a one-cycle frame-done strobe with the assembled byte. If the frame carries no error, the block copies the byte into a readable holding register and raises a "data ready" flag. If a second good frame finishes while that flag is still up, the block raises an overrun flag and drops the new byte. The older byte stays in the holding register.

The CPU reads the holding register and a small status register through a register port. It can clear a flag in only one way: it first reads the status register while the flag is set, and then writes a zero to that flag's bit. A DMA read strobe also empties the holding register, which clears the ready flag.

While overrun is pending, the block refuses further frames and tells the shift path to hold off. In clock-synchronous mode it also tells the transmitter to stop. A standby input clears both flags.

Top module: `rxs_buf_status`

## Requirements
- R1: A good frame (frame_done_i=1, rx_en_i=1, frame_err_i=0, standby_i=0, ovr_o=0) that finds the ready flag clear loads frame_byte_i into the holding register and sets full_o one cycle later.
- R2: Reset sets the holding register to 0x00 and clears both flags and both read-arm bits. While standby_i=1 the block clears both flags and both arm bits, keeps the holding register, and ignores frames.
- R3: A cycle with dma_rd_i=1 clears full_o on the next edge, unless a good frame is accepted in that same cycle.
- R4: A good frame that finds full_o=1 (and no DMA read or software clear of it in that cycle) sets ovr_o. The new byte is discarded and the holding register keeps its earlier value.
- R5: A frame with frame_err_i=1, or any frame while rx_en_i=0, changes neither the holding register nor full_o nor ovr_o.
- R6: While ovr_o=1, frames are ignored and ovr_o stays set. Only reset, standby, or the read-then-write-zero sequence clears it.
- R7: rx_hold_o equals ovr_o. tx_block_o is 1 exactly when ovr_o=1 and sync_mode_i=1.
- R8: The status register sits at reg_sel_i=1, with full at bit 1 and overrun at bit 0. Bit 1 of reg_wdata_i is the full flag's write bit, and bit 0 is the overrun flag's write bit. A status write of 0 clears a flag only if a status read since the last such clear saw that flag as 1; that read arms the flag, and the write of 0 that clears it also disarms it. A write of 1 never sets a flag.
- R9: If a frame-done strobe and a DMA read fall in the same cycle while full_o=1, the DMA read counts first. The new byte is loaded, full_o stays 1, and no overrun is raised.
- R10: reg_rdata_o shows the holding register when reg_sel_i=0 and the status register when reg_sel_i=1. A CPU read of the holding register does not clear full_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low |
| standby_i | input | 1 | Standby: clears flags while high |
| rx_en_i | input | 1 | Receive enable |
| sync_mode_i | input | 1 | Clock-synchronous mode select |
| frame_done_i | input | 1 | Frame completed strobe from shift path |
| frame_err_i | input | 1 | Completed frame had a framing or parity error |
| frame_byte_i | input | 8 | Byte assembled by the shift path |
| dma_rd_i | input | 1 | DMA read of the holding register |
| reg_sel_i | input | 1 | Register select: 0 data, 1 status |
| reg_rd_i | input | 1 | CPU read strobe |
| reg_wr_i | input | 1 | CPU write strobe |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | CPU read data |
| full_o | output | 1 | Holding register contains unread data |
| ovr_o | output | 1 | Overrun pending |
| rx_hold_o | output | 1 | Tells the shift path to stop accepting frames |
| tx_block_o | output | 1 | Tells the transmitter to stop (synchronous mode) |

## Verification
The loading path is tested with a good frame into an empty register, and then with a second frame into a full one. Together these show load versus overrun, and that the old byte is kept. Errored frames and frames with receive disabled show that qualification gates the load. Frames arriving during overrun show that reception is blocked. The flag-clear path is tested with three writes: a zero write with no prior read, a write of ones after a read, and per-bit zero writes after a read. This separates arming from clearing. A frame that lands with a DMA read, a standby pulse between an arming read and a zero write, and a reset part-way through the run exercise the priority and reset rules.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_FULL = 0;
    localparam int unsigned FLAG_OVR  = 1;

    typedef struct packed {
        logic flag;
        logic arm;
    } flag_state_t;
endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic standby_i,
    input  logic rd_seen_i,
    input  logic sw_clr_i,
    input  logic hw_clr_i,
    input  logic set_i,
    output logic flag_o,
    output logic arm_o
);
    import rxs_pkg::*;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (standby_i) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end else begin
            if (sw_clr_i || hw_clr_i) st_d.flag = 1'b0;
            if (set_i)                st_d.flag = 1'b1;
            if (sw_clr_i)                       st_d.arm = 1'b0;
            else if (rd_seen_i && st_q.flag)    st_d.arm = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign arm_o  = st_q.arm;
endmodule

// File: rtl/rxs_hold_reg.sv
module rxs_hold_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i) data_d = byte_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) data_q <= '0;
        else         data_q <= data_d;
    end

    assign data_o = data_q;
endmodule

// File: rtl/rxs_buf_status.sv
module rxs_buf_status #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned FULL_BIT = 1,
    parameter int unsigned OVR_BIT  = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              standby_i,
    input  logic              rx_en_i,
    input  logic              sync_mode_i,
    input  logic              frame_done_i,
    input  logic              frame_err_i,
    input  logic [DATA_W-1:0] frame_byte_i,
    input  logic              dma_rd_i,
    input  logic              reg_sel_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              rx_hold_o,
    output logic              tx_block_o
);
    import rxs_pkg::*;

    localparam int unsigned BIT_POS [NUM_FLAGS] = '{FULL_BIT, OVR_BIT};

    logic [NUM_FLAGS-1:0] flag_q, arm_q, sw_clr, hw_clr, set_v, wr_bit;
    logic [DATA_W-1:0]    data_q;
    logic                 stat_rd, stat_wr, frame_ok, full_eff, load;

    assign stat_rd = reg_rd_i & reg_sel_i;
    assign stat_wr = reg_wr_i & reg_sel_i;

    generate
        for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
            assign wr_bit[g] = reg_wdata_i[BIT_POS[g]];
            assign sw_clr[g] = stat_wr & ~wr_bit[g] & arm_q[g];
            rxs_flag_cell u_cell (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .standby_i (standby_i),
                .rd_seen_i (stat_rd),
                .sw_clr_i  (sw_clr[g]),
                .hw_clr_i  (hw_clr[g]),
                .set_i     (set_v[g]),
                .flag_o    (flag_q[g]),
                .arm_o     (arm_q[g])
            );
        end
    endgenerate

    assign frame_ok = frame_done_i & rx_en_i & ~frame_err_i & ~standby_i & ~flag_q[FLAG_OVR];
    assign full_eff = flag_q[FLAG_FULL] & ~dma_rd_i & ~sw_clr[FLAG_FULL];
    assign load     = frame_ok & ~full_eff;

    assign hw_clr[FLAG_FULL] = dma_rd_i;
    assign hw_clr[FLAG_OVR]  = 1'b0;
    assign set_v[FLAG_FULL]  = load;
    assign set_v[FLAG_OVR]   = frame_ok & full_eff;

    rxs_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .byte_i (frame_byte_i),
        .data_o (data_q)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_sel_i) begin
            reg_rdata_o[FULL_BIT] = flag_q[FLAG_FULL];
            reg_rdata_o[OVR_BIT]  = flag_q[FLAG_OVR];
        end else begin
            reg_rdata_o = data_q;
        end
    end

    assign full_o     = flag_q[FLAG_FULL];
    assign ovr_o      = flag_q[FLAG_OVR];
    assign rx_hold_o  = flag_q[FLAG_OVR];
    assign tx_block_o = flag_q[FLAG_OVR] & sync_mode_i;
endmodule

// File: rtl/rxs_buf_status_chk.sv
module rxs_buf_status_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              standby_i,
    input logic              rx_en_i,
    input logic              sync_mode_i,
    input logic              frame_done_i,
    input logic              frame_err_i,
    input logic              dma_rd_i,
    input logic              reg_wr_i,
    input logic              full_o,
    input logic              ovr_o,
    input logic              rx_hold_o,
    input logic              tx_block_o,
    input logic [DATA_W-1:0] data_q
);
    logic good;
    assign good = frame_done_i & rx_en_i & ~frame_err_i & ~standby_i & ~ovr_o;

    p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (good && !full_o) |=> full_o);

    p_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        standby_i |=> (!full_o && !ovr_o && $stable(data_q)));

    p_dma_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_rd_i && !frame_done_i) |=> !full_o);

    p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (good && full_o && !dma_rd_i && !reg_wr_i) |=> (ovr_o && $stable(data_q)));

    p_bad_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_done_i && (frame_err_i || !rx_en_i) && !dma_rd_i && !reg_wr_i && !standby_i)
            |=> ($stable(data_q) && $stable(full_o) && $stable(ovr_o)));

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_o && !standby_i && !reg_wr_i) |=> (ovr_o && $stable(data_q)));

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_hold_o == ovr_o) && (tx_block_o == (ovr_o && sync_mode_i)));

    p_no_sw_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(full_o) |-> $past(frame_done_i));

    p_ovr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovr_o) |-> $past(frame_done_i && full_o));

    p_same_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (good && full_o && dma_rd_i) |=> (full_o && !ovr_o));
endmodule

bind rxs_buf_status rxs_buf_status_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/rxs_buf_status_tb_top.sv
module rxs_buf_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       standby_i = 0, rx_en_i = 1, sync_mode_i = 0;
    logic       frame_done_i = 0, frame_err_i = 0, dma_rd_i = 0;
    logic [7:0] frame_byte_i = 0;
    logic       reg_sel_i = 0, reg_rd_i = 0, reg_wr_i = 0;
    logic [7:0] reg_wdata_i = 0, reg_rdata_o;
    logic       full_o, ovr_o, rx_hold_o, tx_block_o;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct packed {
        logic       full;
        logic       ovr;
        logic       txb;
        logic [7:0] data;
    } exp_t;
    exp_t exp_q[$];
    string req_q[$];

    logic       m_full = 0, m_ovr = 0, m_af = 0, m_ao = 0;
    logic [7:0] m_data = 0;

    always #2.5 clk = ~clk;

    rxs_buf_status dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby_i), .rx_en_i(rx_en_i),
        .sync_mode_i(sync_mode_i), .frame_done_i(frame_done_i), .frame_err_i(frame_err_i),
        .frame_byte_i(frame_byte_i), .dma_rd_i(dma_rd_i), .reg_sel_i(reg_sel_i),
        .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .full_o(full_o), .ovr_o(ovr_o),
        .rx_hold_o(rx_hold_o), .tx_block_o(tx_block_o)
    );

    task automatic push(input string req);
        exp_t e;
        e.full = m_full; e.ovr = m_ovr; e.txb = m_ovr & sync_mode_i; e.data = m_data;
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    // monitor: compares outputs at the falling edge after each operation
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                exp_t a;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                a.full = full_o; a.ovr = ovr_o; a.txb = tx_block_o; a.data = reg_rdata_o;
                checks++;
                if (a != e || rx_hold_o != ovr_o) begin
                    errors++;
                    $display("FAIL %s: full/ovr/txb/data act %b/%b/%b/%h exp %b/%b/%b/%h (hold %b)",
                             r, a.full, a.ovr, a.txb, a.data, e.full, e.ovr, e.txb, e.data, rx_hold_o);
                end
            end
        end
    end

    // driver: applies one cycle of stimulus, updates the model, queues the expectation
    task automatic op(input logic fd, input logic [7:0] fb, input logic err, input logic en,
                      input logic dma, input logic sel, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic sb, input string req);
        logic sw_f, sw_o, ok, feff, nf, no, naf, nao;
        frame_done_i = fd; frame_byte_i = fb; frame_err_i = err; rx_en_i = en;
        dma_rd_i = dma; reg_sel_i = sel; reg_rd_i = rd; reg_wr_i = wr;
        reg_wdata_i = wd; standby_i = sb;
        if (rd && sel) begin
            #1;
            checks++;
            if (reg_rdata_o !== {6'b0, m_full, m_ovr}) begin
                errors++;
                $display("FAIL R8 status read act %h exp %h", reg_rdata_o, {6'b0, m_full, m_ovr});
            end
        end
        sw_f = wr & sel & ~wd[1] & m_af;
        sw_o = wr & sel & ~wd[0] & m_ao;
        if (sb) begin
            nf = 0; no = 0; naf = 0; nao = 0;
        end else begin
            ok = fd & en & ~err & ~m_ovr;
            feff = m_full & ~dma & ~sw_f;
            nf = (sw_f | dma) ? 1'b0 : m_full;
            no = sw_o ? 1'b0 : m_ovr;
            if (ok && !feff) begin nf = 1; m_data = fb; end
            if (ok && feff) no = 1;
            naf = sw_f ? 1'b0 : ((rd & sel & m_full) ? 1'b1 : m_af);
            nao = sw_o ? 1'b0 : ((rd & sel & m_ovr) ? 1'b1 : m_ao);
        end
        @(posedge clk);
        #1;
        m_full = nf; m_ovr = no; m_af = naf; m_ao = nao;
        frame_done_i = 0; frame_err_i = 0; rx_en_i = 1; dma_rd_i = 0;
        reg_sel_i = 0; reg_rd_i = 0; reg_wr_i = 0; standby_i = 0;
        push(req);
        @(posedge clk);
        #1;
    endtask

    task automatic frame(input logic [7:0] b, input string req);
        op(1, b, 0, 1, 0, 0, 0, 0, 8'h00, 0, req);
    endtask
    task automatic rd_stat(input string req);
        op(0, 0, 0, 1, 0, 1, 1, 0, 8'h00, 0, req);
    endtask
    task automatic wr_stat(input logic [7:0] w, input string req);
        op(0, 0, 0, 1, 0, 1, 0, 1, w, 0, req);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_ni = 1;
        push("R2 reset state");
        @(posedge clk); #1;
        frame(8'hA5, "R1 load into empty");
        op(0, 0, 0, 1, 0, 0, 1, 0, 8'h00, 0, "R10 cpu data read keeps full");
        frame(8'h3C, "R4 overrun keeps old byte");
        sync_mode_i = 1;
        frame(8'h77, "R6 frame ignored during overrun / R7 tx block");
        wr_stat(8'h00, "R8 write zero without read");
        rd_stat("R8 arming read");
        wr_stat(8'hFF, "R8 write ones no effect");
        wr_stat(8'h01, "R8 clear full only");
        wr_stat(8'h00, "R8 clear overrun");
        sync_mode_i = 0;
        op(1, 8'h12, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R5 frame with receive disabled");
        op(1, 8'h34, 1, 1, 0, 0, 0, 0, 8'h00, 0, "R5 errored frame");
        frame(8'h5A, "R1 second load");
        op(1, 8'h66, 1, 1, 0, 0, 0, 0, 8'h00, 0, "R5 errored frame while full");
        op(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R5 receive disable keeps flags");
        op(0, 0, 0, 1, 1, 0, 0, 0, 8'h00, 0, "R3 dma read clears full");
        frame(8'h11, "R1 load after dma");
        op(1, 8'h22, 0, 1, 1, 0, 0, 0, 8'h00, 0, "R9 frame with dma same cycle");
        sync_mode_i = 1;
        frame(8'h33, "R4 overrun second time / R7");
        rd_stat("R8 arm both");
        op(0, 0, 0, 1, 0, 0, 0, 0, 8'h00, 1, "R2 standby clears flags keeps data");
        frame(8'h44, "R2 frame after standby");
        wr_stat(8'h00, "R2 standby disarms write zero");
        op(1, 8'h55, 0, 1, 0, 0, 0, 0, 8'h00, 1, "R2 frame ignored in standby");
        rd_stat("R8 rearm full");
        wr_stat(8'h00, "R8 clear full after read");
        sync_mode_i = 0;
        frame(8'h99, "R1 load before reset");
        rst_ni = 0;
        @(posedge clk); #1;
        rst_ni = 1;
        m_full = 0; m_ovr = 0; m_af = 0; m_ao = 0; m_data = 0;
        push("R2 mid-run reset");
        @(posedge clk); #1;
        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule